// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter Bank

This block turns 1-bit sigma-delta modulator streams into decimated multi-bit samples. Each of its channels receives a modulator clock and a data line from an external modulator, with one data bit per clock period. The channel brings both lines into the system clock domain and captures one bit on each rising edge of the modulator clock. It feeds the bits through three integrators and three differentiators (a CIC of order three), and emits one result after every R bits.

A result is presented in one of two formats. In full-precision form it is the sign-extended integer. In 16-bit form it is arithmetically shifted right by a programmable amount, saturated, and placed in the upper half of a 32-bit word. Every new result gives a one-cycle valid pulse and sets a sticky ready flag, which is cleared by writing one.

A shared master enable gates all channels. Channels that are already enabled when the master enable rises all start from a cleared state on the same clock cycle, so channels that share a modulator clock stay in lockstep.

Top module: `sinc3_bank`

## Requirements
- R1: A channel takes exactly one bit for each rising edge of its modulator clock, after a two-flop synchroniser. A bit value of 1 counts as +1 and a bit value of 0 counts as -1.
- R2: The decimation ratio is R = osr_m1 + 1, with a range of 1 to 256. A running channel produces one result every R bits, and dvalid pulses for one cycle per result.
- R3: The result is the third-order sinc of the bit stream. Take an input whose pattern period divides R, with pattern mean m. From the third result after start onward, the result equals m·R³ exactly. For example, all-ones gives +R³, all-zeros gives -R³, alternating bits give 0, and the pattern 1,1,1,0 gives R³/2.
- R4: With fmt16 = 0, dout carries the result sign-extended to 32 bits. At R = 256 the values reach ±2^24.
- R5: With fmt16 = 1, dout[31:16] holds the result arithmetically shifted right by `shift` bits, and dout[15:0] is zero.
- R6: In 16-bit form, a shifted value above 32767 becomes 32767 (0x7FFF), and a value below -32768 becomes -32768 (0x8000).
- R7: A channel filters only while both master_en and its own ch_en are 1. Otherwise its filter state is held at zero, it produces no dvalid, and its dout keeps its last value.
- R8: Channels enabled before master_en rises, and driven by one common modulator clock, deliver their results on the same cycle.
- R9: drdy is set by each new result. drdy_clr clears it only in a cycle with no new result, because a new result wins over a clear.
- R10: During reset dout, dvalid and drdy are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_clk | input | NCH | Modulator clock per channel |
| mod_dat | input | NCH | Modulator bit per channel |
| master_en | input | 1 | Shared enable for all channels |
| ch_en | input | NCH | Per-channel enable |
| osr_m1 | input | 8 | Decimation ratio minus one |
| fmt16 | input | 1 | 1 selects the shifted 16-bit format |
| shift | input | 5 | Right-shift amount for the 16-bit format |
| drdy_clr | input | NCH | Write-one-to-clear for drdy |
| dout | output | 32·NCH | Latest result per channel, 32 bits each |
| dvalid | output | NCH | One-cycle pulse per new result |
| drdy | output | NCH | Sticky new-result flag |

## Verification
The clear of the ready flag and the setting of that flag by a new result can happen in the same clock cycle. The bench forces this case by holding drdy_clr high through a whole filtering run, so that the clear is asserted on every cycle in which a result lands. At each cycle where dvalid is high, the flag must read 1, because the set must win. Once the run stops and the clear is still asserted, the flag must read 0.

// File: rtl/sinc3_pkg.sv
`timescale 1ns/1ps
package sinc3_pkg;
  localparam int OSR_MAX = 256;
  localparam int ACC_W   = 3 * $clog2(OSR_MAX) + 2;
  localparam int OUT_W   = 32;
  localparam int HALF_W  = OUT_W / 2;
  localparam int SH_W    = 5;

  typedef logic signed [ACC_W-1:0] acc_t;

  localparam acc_t ACC_HI = acc_t'(32767);
  localparam acc_t ACC_LO = acc_t'(-32768);

  // maps a modulator bit onto +1 / -1
  function automatic acc_t bit_to_pm(input logic b);
    return b ? acc_t'(1) : acc_t'(-1);
  endfunction

  // full-precision word: sign extension of the raw result
  function automatic logic [OUT_W-1:0] widen(input acc_t v);
    return {{(OUT_W-ACC_W){v[ACC_W-1]}}, v};
  endfunction

  // shifted, saturated 16-bit value in the upper half, lower half zero
  function automatic logic [OUT_W-1:0] narrow(input acc_t v, input logic [SH_W-1:0] sh);
    acc_t s;
    logic [HALF_W-1:0] h;
    s = v >>> sh;
    if (s > ACC_HI)      h = 16'h7FFF;
    else if (s < ACC_LO) h = 16'h8000;
    else                 h = s[HALF_W-1:0];
    return {h, {HALF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/sdm_capture.sv
`timescale 1ns/1ps
module sdm_capture #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_i,
  input  logic mdat_i,
  output logic bit_stb,
  output logic bit_val
);
  logic [SYNC_N:0]   ck_sh;
  logic [SYNC_N-1:0] dt_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_sh <= '0;
      dt_sh <= '0;
    end else begin
      ck_sh <= {ck_sh[SYNC_N-1:0], mclk_i};
      dt_sh <= {dt_sh[SYNC_N-2:0], mdat_i};
    end
  end

  // rising modulator clock seen after synchronisation (R1)
  assign bit_stb = ck_sh[SYNC_N-1] & ~ck_sh[SYNC_N];
  assign bit_val = dt_sh[SYNC_N-1];
endmodule

// File: rtl/sinc3_core.sv
`timescale 1ns/1ps
module sinc3_core
  import sinc3_pkg::*;
#(
  parameter int OSR_W = $clog2(OSR_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bit_stb,
  input  logic             bit_val,
  input  logic [OSR_W-1:0] osr_m1,
  output logic             dec_o,
  output acc_t             comb_o
);
  acc_t i1, i2, i3, d1, d2, d3;
  acc_t i1n, i2n, i3n, c1, c2, c3;
  logic [OSR_W-1:0] cnt;
  logic last_bit;

  always_comb begin
    i1n = i1 + bit_to_pm(bit_val);
    i2n = i2 + i1n;
    i3n = i3 + i2n;
    c1  = i3n - d1;
    c2  = c1 - d2;
    c3  = c2 - d3;
  end

  assign last_bit = (cnt >= osr_m1);
  assign dec_o    = run & bit_stb & last_bit;
  assign comb_o   = c3;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      i1 <= '0; i2 <= '0; i3 <= '0;
      d1 <= '0; d2 <= '0; d3 <= '0;
      cnt <= '0;
    end else if (bit_stb) begin
      i1 <= i1n;
      i2 <= i2n;
      i3 <= i3n;
      if (last_bit) begin
        cnt <= '0;
        d1  <= i3n;
        d2  <= c1;
        d3  <= c2;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7: a stopped channel has cleared state on the next cycle
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (i1 == '0 && i3 == '0 && cnt == '0));

  // R1: the integrators move only on a captured bit
  p_onebit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_stb) ##1 run |-> $stable(i1) && $stable(i3));
endmodule

// File: rtl/sinc3_bank.sv
`timescale 1ns/1ps
module sinc3_bank
  import sinc3_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int OSR_W  = $clog2(OSR_MAX),
  parameter int SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       mod_clk,
  input  logic [NCH-1:0]       mod_dat,
  input  logic                 master_en,
  input  logic [NCH-1:0]       ch_en,
  input  logic [OSR_W-1:0]     osr_m1,
  input  logic                 fmt16,
  input  logic [SH_W-1:0]      shift,
  input  logic [NCH-1:0]       drdy_clr,
  output logic [NCH*OUT_W-1:0] dout,
  output logic [NCH-1:0]       dvalid,
  output logic [NCH-1:0]       drdy
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic             run, stb, bval, dec;
    acc_t             raw;
    logic [OUT_W-1:0] fmt_w, dout_q;
    logic             dv_q, rdy_q;

    // master enable gates every channel so all start together (R7, R8)
    assign run = master_en & ch_en[g];

    sdm_capture #(.SYNC_N(SYNC_N)) u_cap (
      .clk(clk), .rst_n(rst_n), .mclk_i(mod_clk[g]), .mdat_i(mod_dat[g]),
      .bit_stb(stb), .bit_val(bval)
    );

    sinc3_core #(.OSR_W(OSR_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(run), .bit_stb(stb), .bit_val(bval),
      .osr_m1(osr_m1), .dec_o(dec), .comb_o(raw)
    );

    assign fmt_w = fmt16 ? narrow(raw, shift) : widen(raw);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dout_q <= '0;
        dv_q   <= 1'b0;
        rdy_q  <= 1'b0;
      end else begin
        dv_q <= dec;
        if (dec) begin
          dout_q <= fmt_w;
          rdy_q  <= 1'b1;
        end else if (drdy_clr[g]) begin
          rdy_q  <= 1'b0;
        end
      end
    end

    assign dout[g*OUT_W +: OUT_W] = dout_q;
    assign dvalid[g] = dv_q;
    assign drdy[g]   = rdy_q;

    p_drdy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid[g] |-> drdy[g]);
    p_drdy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      drdy[g] && !drdy_clr[g] |=> drdy[g]);
    p_drdy_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      drdy_clr[g] && !dec |=> !drdy[g]);
    p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid[g] && $past(fmt16) |-> dout[g*OUT_W +: HALF_W] == '0);
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(master_en && ch_en[g]) |=> !dvalid[g]);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dvalid[g] |-> $stable(dout[g*OUT_W +: OUT_W]));
  end
endmodule

// File: tb/sinc3_bank_test.sv
`timescale 1ns/1ps
module sinc3_bank_test;
  localparam int NCH = 4;
  localparam int MPER = 6;

  typedef struct packed {
    logic [1:0]  ch;
    logic        dc;
    logic [31:0] val;
  } item_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              mclk = 1'b1;
  logic [NCH-1:0]    mdat = '0;
  logic              master_en = 1'b0;
  logic [NCH-1:0]    ch_en = '0;
  logic [7:0]        osr_m1 = 8'd255;
  logic              fmt16 = 1'b0;
  logic [4:0]        shift = '0;
  logic [NCH-1:0]    drdy_clr = '0;
  logic [NCH*32-1:0] dout;
  logic [NCH-1:0]    dvalid, drdy;

  sinc3_bank uut (
    .clk(clk), .rst_n(rst_n), .mod_clk({NCH{mclk}}), .mod_dat(mdat),
    .master_en(master_en), .ch_en(ch_en), .osr_m1(osr_m1), .fmt16(fmt16),
    .shift(shift), .drdy_clr(drdy_clr), .dout(dout), .dvalid(dvalid), .drdy(drdy)
  );

  int n_chk = 0;
  int n_fail = 0;
  item_t sbq[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // modulator: ch0 all ones, ch1 all zeros, ch2 alternating, ch3 1,1,1,0
  int bidx = 0;
  initial forever begin
    repeat (MPER/2) @(negedge clk);
    mclk = 1'b0;
    bidx++;
    mdat[0] = 1'b1;
    mdat[1] = 1'b0;
    mdat[2] = bidx[0];
    mdat[3] = ((bidx % 4) != 3);
    repeat (MPER/2) @(negedge clk);
    mclk = 1'b1;
  end

  function automatic logic [31:0] as16(input int v, input int sh);
    int s;
    s = v >>> sh;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return {s[15:0], 16'h0000};
  endfunction

  // monitor: pops the scoreboard as results appear
  int cyc = 0;
  int last_t = -1;
  always @(negedge clk) begin
    item_t it;
    cyc++;
    if (!master_en) last_t = -1;
    if (dvalid[0]) begin
      if (last_t >= 0) chk("R2 result spacing", 32'(cyc - last_t), 32'((int'(osr_m1) + 1) * MPER));
      last_t = cyc;
    end
    if (dvalid != '0 && ch_en == {NCH{1'b1}}) chk("R8 lockstep", 32'(dvalid), 32'hF);
    for (int c = 0; c < NCH; c++) begin
      if (dvalid[c]) begin
        if (sbq.size() == 0) begin
          chk("R7 unexpected result", 32'(c), 32'hFFFF_FFFF);
        end else begin
          it = sbq.pop_front();
          if (32'(it.ch) != 32'(c)) chk("R7 result channel", 32'(c), 32'(it.ch));
          else if (!it.dc) chk("R3 value (R4/R5/R6 format)", dout[c*32 +: 32], it.val);
        end
        if (drdy_clr[c]) chk("R9 set beats clear", 32'(drdy[c]), 32'd1);
      end
    end
  end

  task automatic run_case(input logic [7:0] om, input logic f, input logic [4:0] sh,
                          input logic [NCH-1:0] en, input logic [NCH-1:0][31:0] ev);
    item_t it;
    int t;
    @(negedge clk);
    osr_m1 = om; fmt16 = f; shift = sh; ch_en = en;
    for (int k = 0; k < 5; k++)
      for (int c = 0; c < NCH; c++)
        if (en[c]) begin
          it.ch = 2'(c); it.dc = (k < 2); it.val = ev[c];
          sbq.push_back(it);
        end
    @(negedge clk);
    master_en = 1'b1;
    t = 0;
    while (sbq.size() != 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (sbq.size() != 0) begin
      chk("R2 results missing", 32'(sbq.size()), 32'd0);
      sbq.delete();
    end
    @(negedge clk);
    master_en = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int n3;
    logic [NCH-1:0][31:0] ev;
    repeat (4) @(negedge clk);
    chk("R10 reset dout", dout[31:0] | dout[63:32] | dout[95:64] | dout[127:96], 32'd0);
    chk("R10 reset dvalid", 32'(dvalid), 32'd0);
    chk("R10 reset drdy", 32'(drdy), 32'd0);
    rst_n = 1'b1;

    // R7: enabled channels stay idle without master enable
    ch_en = '1;
    repeat (300) @(negedge clk);
    chk("R7 idle drdy", 32'(drdy), 32'd0);
    chk("R7 idle dout", dout[31:0], 32'd0);

    // R4, R3: ratio 256, full precision
    n3 = 256 * 256 * 256;
    ev[0] = 32'(n3); ev[1] = 32'(-n3); ev[2] = 32'd0; ev[3] = 32'(n3 / 2);
    run_case(8'd255, 1'b0, 5'd0, 4'hF, ev);
    chk("R9 sticky", 32'(drdy), 32'hF);
    drdy_clr = '1;
    @(negedge clk);
    drdy_clr = '0;
    chk("R9 cleared", 32'(drdy), 32'd0);

    // R5, R6: ratio 256, shift 9, positive full scale saturates
    ev[0] = as16(n3, 9); ev[1] = as16(-n3, 9); ev[2] = 32'd0; ev[3] = as16(n3 / 2, 9);
    run_case(8'd255, 1'b1, 5'd9, 4'hF, ev);
    chk("R6 saturated word", ev[0], 32'h7FFF_0000);

    // R2, R3: ratio 16, full precision
    n3 = 16 * 16 * 16;
    ev[0] = 32'(n3); ev[1] = 32'(-n3); ev[2] = 32'd0; ev[3] = 32'(n3 / 2);
    run_case(8'd15, 1'b0, 5'd0, 4'hF, ev);

    // R9 collision: clear held high across every new result
    drdy_clr = '1;
    ev[0] = as16(n3, 2); ev[1] = as16(-n3, 2); ev[2] = 32'd0; ev[3] = as16(n3 / 2, 2);
    run_case(8'd15, 1'b1, 5'd2, 4'hF, ev);
    chk("R9 clear after run", 32'(drdy), 32'd0);
    drdy_clr = '0;

    // R7: only channels 0 and 2 enabled
    ev[0] = 32'(n3); ev[1] = 32'd0; ev[2] = 32'd0; ev[3] = 32'd0;
    run_case(8'd15, 1'b0, 5'd0, 4'b0101, ev);
    chk("R7 ch1 dout held", dout[63:32], 32'hFC00_0000);
    chk("R7 ch3 dout held", dout[127:96], 32'h0200_0000);
    chk("R7 drdy only enabled", 32'(drdy), 32'b0101);

    finish_up();
  end
endmodule